// File: doc/BRIEF.md
# Reference Source and Mode Controller

This block decides how a clock-synthesis core runs, based on register settings and on status reported by the analog blocks around it. Software picks the reference with a source-select field. One code picks the crystal/reference port. Each of the other codes picks one of three clock inputs. A separate bit tells the block whether the crystal port is driven by a crystal or by an external reference clock.

The block reports one of five modes and gates the output clocks.
- With the crystal port selected and an oscillator present, it runs free.
- With a clock input selected, it waits for that input to be valid and then waits for the PLL to report lock before it lets the outputs run.
- If the selected input drops, the outputs stop and stay stopped until software writes a different selection. The block never falls back to another input by itself.

The block also drives two static controls for the reference path. The first enables the internal load capacitors, which are used only in crystal mode. The second enables a pre-divider, which is used when an external reference runs above 54 MHz. The clock-valid flags and the lock flag are asynchronous and pass through two-flop synchronizers.

Top module: `refsel_ctrl`

## Requirements
- R1: With `src_sel` = 0 (crystal/reference port) and `osc_present` high, the state moves from IDLE to FREERUN on the next clock edge, and `out_en` is 1 while in FREERUN. A low `osc_present` in FREERUN returns the state to IDLE on the next edge.
- R2: `out_en` is 1 only in FREERUN or LOCKED. When `src_sel` is not 0, FREERUN is never entered, even if `osc_present` is high.
- R3: `src_sel` codes 1, 2 and 3 select clock inputs 0, 1 and 2, which are bits 0, 1 and 2 of `clk_valid`. From IDLE, a synchronized valid flag on the selected input moves the state to ACQUIRING. Valid flags on inputs that are not selected have no effect.
- R4: From ACQUIRING, the state moves to LOCKED only when the synchronized `pll_locked` is high, and `out_en` is 0 in ACQUIRING. Loss of lock in LOCKED returns the state to ACQUIRING.
- R5: Loss of the selected input's valid flag in ACQUIRING or LOCKED moves the state to HOLD_OFF with `out_en` = 0. HOLD_OFF persists, whatever happens on `clk_valid` and `pll_locked`, as long as `src_sel` is unchanged.
- R6: `cap_en` is 1 exactly when `ref_is_clk` is 0, that is, in crystal mode. This is combinational, with no added cycles.
- R7: Any change of `src_sel` forces the state to IDLE on the next clock edge, whatever the current state.
- R8: `prediv_en` is 1 exactly when `ref_is_clk` and `ref_hi_freq` are both 1. This is combinational.
- R9: A change on `clk_valid` or `pll_locked` affects the state no earlier than the third rising edge after it, because of the two synchronizer flops.
- R10: `mode` encodes IDLE=0, FREERUN=1, ACQUIRING=2, LOCKED=3 and HOLD_OFF=4. Reset gives IDLE with `out_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Source select: 0 crystal/reference port, 1..3 clock inputs 0..2 |
| ref_is_clk | input | 1 | 1 = external reference clock on the crystal port, 0 = crystal |
| osc_present | input | 1 | Oscillator/reference detected on the crystal port |
| clk_valid | input | 3 | Per-input clock-valid flags (asynchronous) |
| pll_locked | input | 1 | PLL lock flag (asynchronous) |
| ref_hi_freq | input | 1 | External reference is above 54 MHz |
| mode | output | 3 | Current mode (encoding in R10) |
| out_en | output | 1 | Output clock enable |
| cap_en | output | 1 | Internal crystal load capacitor enable |
| prediv_en | output | 1 | Reference pre-divider enable |

## Verification
The outputs follow different latencies.
- `cap_en` and `prediv_en` follow their inputs within the same cycle.
- A `src_sel` write reaches `mode` at the first rising edge.
- A transition out of IDLE that depends only on `src_sel` and `osc_present` lands one edge later.
- Edges on `clk_valid` or `pll_locked` reach `mode` at the third rising edge, after two synchronizer flops and the state register.

The bench drives each stimulus on a falling edge and waits an exact number of rising edges before it queues the expected result. It also samples the design once one or two edges early, to confirm that a synchronized change has not yet arrived.

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int NUM_IN      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_IN + 1),
  localparam int SW         = NUM_IN + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             ref_is_clk,
  input  logic             osc_present,
  input  logic [NUM_IN-1:0] clk_valid,
  input  logic             pll_locked,
  input  logic             ref_hi_freq,
  output logic [2:0]       mode,
  output logic             out_en,
  output logic             cap_en,
  output logic             prediv_en
);

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FREERUN = 3'd1,
    ST_ACQ     = 3'd2,
    ST_LOCKED  = 3'd3,
    ST_HOLD    = 3'd4
  } state_t;

  state_t state, state_nx;
  logic [SEL_W-1:0] sel_q;
  logic [SYNC_STAGES-1:0][SW-1:0] sync_q;
  logic [NUM_IN-1:0] vld_s;
  logic lock_s, sel_chg, sel_valid, xtal_src;

  // R9: asynchronous flags go through a synchronizer chain
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], {pll_locked, clk_valid}};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {pll_locked, clk_valid};
      end
    end
  endgenerate

  assign vld_s  = sync_q[SYNC_STAGES-1][NUM_IN-1:0];
  assign lock_s = sync_q[SYNC_STAGES-1][NUM_IN];

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= src_sel;
  end

  assign sel_chg  = (src_sel != sel_q);
  assign xtal_src = (src_sel == '0);

  always_comb begin
    sel_valid = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      if (src_sel == SEL_W'(i + 1)) sel_valid = vld_s[i];
  end

  always_comb begin
    state_nx = state;
    if (sel_chg) state_nx = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: begin
          if (xtal_src) begin
            if (osc_present) state_nx = ST_FREERUN;
          end else if (sel_valid) state_nx = ST_ACQ;
        end
        ST_FREERUN: if (!osc_present) state_nx = ST_IDLE;
        ST_ACQ: begin
          if (!sel_valid)  state_nx = ST_HOLD;
          else if (lock_s) state_nx = ST_LOCKED;
        end
        ST_LOCKED: begin
          if (!sel_valid)   state_nx = ST_HOLD;
          else if (!lock_s) state_nx = ST_ACQ;
        end
        ST_HOLD: state_nx = ST_HOLD;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign mode      = state;
  assign out_en    = (state == ST_FREERUN) || (state == ST_LOCKED);
  assign cap_en    = ~ref_is_clk;
  assign prediv_en = ref_is_clk & ref_hi_freq;

  // R7
  sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != sel_q) |=> (mode == 3'd0));

  // R5
  hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && src_sel == sel_q) |=> (mode == 3'd4));

  // R2
  no_freerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd1 && src_sel != '0) |=> (mode != 3'd1));

  // R4
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !lock_s) |=> !out_en);

  // R10
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

endmodule

// File: tb/tb_refsel_ctrl.sv
module tb_refsel_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = '0;
  logic ref_is_clk = 1'b0, osc_present = 1'b0, pll_locked = 1'b0, ref_hi_freq = 1'b0;
  logic [2:0] clk_valid = '0;
  logic [2:0] mode;
  logic out_en, cap_en, prediv_en;

  typedef struct {
    logic [2:0] m;
    logic en, cap, pre;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  refsel_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ref_is_clk(ref_is_clk),
    .osc_present(osc_present), .clk_valid(clk_valid), .pll_locked(pll_locked),
    .ref_hi_freq(ref_hi_freq), .mode(mode), .out_en(out_en), .cap_en(cap_en),
    .prediv_en(prediv_en)
  );

  always begin
    @(posedge clk);
    #5;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (mode !== e.m || out_en !== e.en || cap_en !== e.cap || prediv_en !== e.pre) begin
        errors++;
        $display("FAIL %s: mode/en/cap/pre got %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                 e.req, mode, out_en, cap_en, prediv_en, e.m, e.en, e.cap, e.pre);
      end
    end
  end

  task automatic step(input logic [1:0] s, input logic rc, input logic pr,
                      input logic [2:0] v, input logic lk, input logic hi, input int n,
                      input logic [2:0] m, input logic en, input logic cap,
                      input logic pre, input string req);
    exp_t e;
    @(negedge clk);
    src_sel = s; ref_is_clk = rc; osc_present = pr;
    clk_valid = v; pll_locked = lk; ref_hi_freq = hi;
    repeat (n) @(posedge clk);
    #1;
    e.m = m; e.en = en; e.cap = cap; e.pre = pre; e.req = req;
    q.push_back(e);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(0, 0, 0, 3'b000, 0, 0, 1, 0, 0, 1, 0, "R10 reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 3'b000, 0, 0, 2, 0, 0, 1, 0, "R2 no osc");
    step(0, 0, 1, 3'b000, 0, 0, 1, 1, 1, 1, 0, "R1 freerun");
    step(0, 0, 0, 3'b000, 0, 0, 1, 0, 0, 1, 0, "R1 osc loss");
    step(0, 0, 1, 3'b000, 0, 0, 1, 1, 1, 1, 0, "R1 freerun again");
    step(2, 0, 1, 3'b000, 0, 0, 1, 0, 0, 1, 0, "R7 sel change");
    step(2, 0, 1, 3'b000, 0, 0, 1, 0, 0, 1, 0, "R2 no freerun on input sel");
    step(2, 0, 1, 3'b101, 0, 0, 3, 0, 0, 1, 0, "R3 unselected valid ignored");
    step(2, 0, 1, 3'b010, 0, 0, 2, 0, 0, 1, 0, "R9 valid not yet through");
    step(2, 0, 1, 3'b010, 0, 0, 1, 2, 0, 1, 0, "R3 acquiring");
    step(2, 0, 1, 3'b010, 1, 0, 2, 2, 0, 1, 0, "R9 lock not yet through");
    step(2, 0, 1, 3'b010, 1, 0, 1, 3, 1, 1, 0, "R4 locked");
    step(2, 0, 1, 3'b010, 0, 0, 3, 2, 0, 1, 0, "R4 lock loss");
    step(2, 0, 1, 3'b010, 1, 0, 3, 3, 1, 1, 0, "R4 relock");
    step(2, 0, 1, 3'b000, 1, 0, 3, 4, 0, 1, 0, "R5 input fail");
    step(2, 0, 1, 3'b110, 1, 0, 5, 4, 0, 1, 0, "R5 hold persists");
    step(3, 0, 1, 3'b110, 1, 0, 1, 0, 0, 1, 0, "R7 restart from hold");
    step(3, 0, 1, 3'b110, 1, 0, 1, 2, 0, 1, 0, "R3 new input acquiring");
    step(3, 0, 1, 3'b110, 1, 0, 1, 3, 1, 1, 0, "R4 new input locked");
    step(1, 0, 1, 3'b110, 1, 0, 1, 0, 0, 1, 0, "R7 restart from locked");
    step(1, 0, 1, 3'b110, 1, 0, 2, 0, 0, 1, 0, "R3 invalid input stays idle");
    step(1, 1, 1, 3'b110, 1, 0, 1, 0, 0, 0, 0, "R6 ref clk caps off");
    step(1, 1, 1, 3'b110, 1, 1, 1, 0, 0, 0, 1, "R8 prediv on");
    step(1, 0, 1, 3'b110, 1, 1, 1, 0, 0, 1, 0, "R8 crystal no prediv");
    step(0, 1, 1, 3'b110, 1, 1, 1, 0, 0, 0, 1, "R7 back to port");
    step(0, 1, 1, 3'b110, 1, 1, 1, 1, 1, 0, 1, "R1 freerun on ref clk");
    @(posedge clk); #8;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule